// File: doc/BRIEF.md
# Cache line permission tracker

This block holds the status bits of every line of a small direct-mapped cache and decides, in the same cycle a CPU request arrives, whether the request is a hit. A request carries an address, a flag for exclusive (write) permission and a flag for a writeback. Reads hit only when the line is readable. Exclusive requests hit only when the line is writable. A miss is recorded in a small fully associative miss table, or merged into an entry already open for the same line. Fill responses close an entry and install the line, either as a shared copy or as an exclusive one.

The readable bit is kept apart from the valid bit. When an exclusive request misses on a resident line that is not writable, the line stays valid and keeps its place, so an upgrade response with no data can still complete. It stops serving reads until the fill arrives, so a read can never return data that an outstanding write is about to change. A lookup port shows the status of any address so that the line state can be observed. When a request and a fill touch the same set in one cycle, the fill decides the final status of that set.

Top module: `line_perm_tracker`

## Requirements
- R1: The lookup port returns the status of the line that an address maps to when the stored tag matches, and 0 otherwise. The bit meanings are bit0 valid, bit1 writable, bit2 readable, bit3 dirty and bit4 referenced. Readable is never set without valid.
- R2: A non-exclusive, non-writeback request hits only when the line's tag matches and both the valid and readable bits are set. Otherwise it is a miss.
- R3: An exclusive request hits only when the line's tag matches and its writable bit is set. Otherwise it is a miss.
- R4: A non-writeback hit sets the referenced bit of the line.
- R5: An exclusive miss that opens a new table entry on a resident line clears that line's readable bit and keeps it valid. Later reads of that line miss.
- R6: A fill that matches an open entry installs the tag with status valid+readable+writable (0x07) when the shared flag is low, and valid+readable (0x05) when it is high. Entries opened by exclusive requests never receive a shared fill.
- R7: A fill frees its matching table entry. A fill that matches no open entry changes nothing.
- R8: A writeback always reports a hit and never opens a table entry. It adds the dirty bit to a resident line. On an absent line it installs the tag with status valid+readable+dirty (0x0D).
- R9: The table is searched by the line address, which ignores the 4 offset bits. A miss that matches an open entry reports a miss and changes neither the table nor the line status.
- R10: The stall output is high whenever all 4 entries are open. While stalled, a miss that needs a new entry reports neither hit nor miss and changes nothing, while hits and merges are still served.
- R11: After reset no line has status bits set, the table is empty and stall, hit and miss are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_addr | input | 32 | Request byte address |
| req_excl | input | 1 | Request needs write permission |
| req_wb | input | 1 | Request is a writeback |
| hit | output | 1 | Request satisfied this cycle |
| miss | output | 1 | Request missed and was recorded or merged |
| stall | output | 1 | Miss table full |
| fill_valid | input | 1 | Fill response present |
| fill_addr | input | 32 | Fill byte address |
| fill_shared | input | 1 | Fill grants a shared copy only |
| peek_addr | input | 32 | Lookup port address |
| peek_status | output | 5 | Status bits of the looked-up line |

## Verification
The assertions assume that a fill with the shared flag never closes an entry opened by an exclusive request, and that a fill and a request never name the same set in one cycle when the post-cycle status is checked. The stimulus respects both rules. It picks the shared flag only for entries it knows were opened by reads. It issues requests and fills in separate cycles, and it keeps its own copy of the open entries. The addresses come from three tags and four sets, which makes conflicts, merges and a full table frequent.

// File: rtl/line_perm_tracker.sv
module line_perm_tracker #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int SETS       = 16,
  parameter int MSHR_N     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_excl,
  input  logic              req_wb,
  output logic              hit,
  output logic              miss,
  output logic              stall,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic              fill_shared,
  input  logic [ADDR_W-1:0] peek_addr,
  output logic [4:0]        peek_status
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int LA_W   = ADDR_W - OFF_W;
  localparam int SLOT_W = (MSHR_N > 1) ? $clog2(MSHR_N) : 1;
  localparam logic [4:0] ST_V = 5'h01, ST_W = 5'h02, ST_R = 5'h04, ST_D = 5'h08, ST_F = 5'h10;

  logic [TAG_W-1:0] tag_q  [SETS];
  logic [4:0]       stat_q [SETS];
  logic [MSHR_N-1:0] ent_v;
  logic [LA_W-1:0]  ent_la [MSHR_N];
  logic [MSHR_N-1:0] ent_x;

  wire [IDX_W-1:0] r_idx = req_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0] r_tag = req_addr[ADDR_W-1 -: TAG_W];
  wire [LA_W-1:0]  r_la  = req_addr[ADDR_W-1:OFF_W];
  wire [IDX_W-1:0] f_idx = fill_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0] f_tag = fill_addr[ADDR_W-1 -: TAG_W];
  wire [LA_W-1:0]  f_la  = fill_addr[ADDR_W-1:OFF_W];
  wire [IDX_W-1:0] p_idx = peek_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0] p_tag = peek_addr[ADDR_W-1 -: TAG_W];

  wire [4:0] cur     = stat_q[r_idx];
  wire       present = cur[0] && (tag_q[r_idx] == r_tag);
  wire       can     = req_excl ? cur[1] : (cur[0] && cur[2]);
  wire       lk_hit  = present && can;

  logic              r_match, f_match, free_ok, f_excl;
  logic [SLOT_W-1:0] f_slot, free_slot;

  always_comb begin
    r_match = 1'b0;
    f_match = 1'b0;
    f_slot = '0;
    free_ok = 1'b0;
    free_slot = '0;
    for (int i = MSHR_N - 1; i >= 0; i--) begin
      if (ent_v[i] && ent_la[i] == r_la) r_match = 1'b1;
      if (ent_v[i] && ent_la[i] == f_la) begin
        f_match = 1'b1;
        f_slot = SLOT_W'(i);
      end
      if (!ent_v[i]) begin
        free_ok = 1'b1;
        free_slot = SLOT_W'(i);
      end
    end
  end
  assign f_excl = ent_x[f_slot];

  assign stall = &ent_v;
  wire need  = req_valid && !req_wb && !lk_hit;
  wire alloc = need && !r_match && free_ok;
  assign hit  = req_valid && (req_wb || lk_hit);
  assign miss = need && (r_match || free_ok);
  assign peek_status = (tag_q[p_idx] == p_tag) ? stat_q[p_idx] : 5'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        tag_q[s]  <= '0;
        stat_q[s] <= '0;
      end
      for (int i = 0; i < MSHR_N; i++) ent_la[i] <= '0;
      ent_v <= '0;
      ent_x <= '0;
    end else begin
      if (req_valid && req_wb) begin
        if (present) stat_q[r_idx] <= cur | ST_D;
        else begin
          tag_q[r_idx]  <= r_tag;
          stat_q[r_idx] <= ST_V | ST_R | ST_D;
        end
      end else if (hit) begin
        stat_q[r_idx] <= cur | ST_F;
      end else if (alloc) begin
        ent_v[free_slot]  <= 1'b1;
        ent_la[free_slot] <= r_la;
        ent_x[free_slot]  <= req_excl;
        if (present && req_excl) stat_q[r_idx] <= cur & ~ST_R;
      end
      if (fill_valid && f_match) begin
        tag_q[f_idx]  <= f_tag;
        stat_q[f_idx] <= ST_V | ST_R | (fill_shared ? 5'h00 : ST_W);
        ent_v[f_slot] <= 1'b0;
      end
    end
  end

  assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && miss));

  assert_full_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stall && !fill_valid |=> stall);

  assert_upgrade_keeps_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    alloc && present && req_excl && !fill_valid
    |=> (stat_q[$past(r_idx)] & (ST_V | ST_R)) == ST_V);

  assert_fill_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && f_match && !req_valid
    |=> stat_q[$past(f_idx)][0] && stat_q[$past(f_idx)][2]
        && (stat_q[$past(f_idx)][1] == !$past(fill_shared)));

  assert_no_shared_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && f_match && fill_shared |-> !f_excl);

  assert_ref_on_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !req_wb && !fill_valid |=> stat_q[$past(r_idx)][4]);

  for (genvar s = 0; s < SETS; s++) begin : g_inv
    assert_readable_needs_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
      stat_q[s][2] |-> stat_q[s][0]);
  end
endmodule

// File: tb/tb_line_perm_tracker.sv
module tb_line_perm_tracker;
  localparam int PERIOD = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_excl = 0, req_wb = 0, fill_valid = 0, fill_shared = 0;
  logic [31:0] req_addr = '0, fill_addr = '0, peek_addr = '0;
  logic hit, miss, stall;
  logic [4:0] peek_status;

  line_perm_tracker dut (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_excl(req_excl), .req_wb(req_wb), .hit(hit), .miss(miss), .stall(stall),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_shared(fill_shared),
    .peek_addr(peek_addr), .peek_status(peek_status));

  always #(PERIOD/2) clk = ~clk;

  int n_chk = 0, n_err = 0;
  bit finished = 0;
  logic [23:0] m_tag [16];
  logic [4:0]  m_st  [16];
  bit          ev [4];
  logic [27:0] ea [4];
  bit          ex [4];

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int t, input int s, input int o);
    return {t[23:0], s[3:0], o[3:0]};
  endfunction
  function automatic int find(input logic [27:0] la);
    for (int i = 0; i < 4; i++) if (ev[i] && ea[i] == la) return i;
    return -1;
  endfunction
  function automatic int free_slot();
    for (int i = 0; i < 4; i++) if (!ev[i]) return i;
    return -1;
  endfunction
  function automatic logic [4:0] m_peek(input logic [31:0] a);
    return (m_tag[a[7:4]] == a[31:8]) ? m_st[a[7:4]] : 5'h00;
  endfunction

  task automatic do_req(input logic [31:0] a, input bit x, input bit wb, input string rq);
    bit pres, eh, need, full, em;
    int f, s;
    @(negedge clk);
    req_valid = 1; req_addr = a; req_excl = x; req_wb = wb; peek_addr = a;
    #1;
    s = a[7:4];
    pres = m_st[s][0] && m_tag[s] == a[31:8];
    eh = wb || (pres && (x ? m_st[s][1] : (m_st[s][0] && m_st[s][2])));
    need = !wb && !eh;
    f = find(a[31:4]);
    full = (free_slot() < 0);
    em = need && (f >= 0 || !full);
    chk({rq, " hit"}, 32'(hit), 32'(eh));
    chk({rq, " miss"}, 32'(miss), 32'(em));
    chk("R10 stall", 32'(stall), 32'(full));
    @(posedge clk); #1;
    req_valid = 0;
    if (wb) begin
      if (pres) m_st[s] |= 5'h08;
      else begin m_tag[s] = a[31:8]; m_st[s] = 5'h0D; end
    end else if (eh) m_st[s] |= 5'h10;
    else if (need && f < 0 && !full) begin
      int k = free_slot();
      ev[k] = 1; ea[k] = a[31:4]; ex[k] = x;
      if (pres && x) m_st[s] &= ~5'h04;
    end
    #1 chk({rq, " R1 status"}, 32'(peek_status), 32'(m_peek(a)));
  endtask

  task automatic do_fill(input logic [31:0] a, input bit sh, input string rq);
    int f;
    @(negedge clk);
    fill_valid = 1; fill_addr = a; fill_shared = sh; peek_addr = a;
    @(posedge clk); #1;
    fill_valid = 0;
    f = find(a[31:4]);
    if (f >= 0) begin
      m_tag[a[7:4]] = a[31:8];
      m_st[a[7:4]] = sh ? 5'h05 : 5'h07;
      ev[f] = 0;
    end
    #1 chk({rq, " status"}, 32'(peek_status), 32'(m_peek(a)));
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] A;
    for (int i = 0; i < 16; i++) begin m_tag[i] = '0; m_st[i] = '0; end
    for (int i = 0; i < 4; i++) begin ev[i] = 0; ea[i] = '0; ex[i] = 0; end
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    peek_addr = mk(1, 1, 0);
    #1;
    chk("R11 stall", 32'(stall), 0);
    chk("R11 hit", 32'(hit), 0);
    chk("R11 miss", 32'(miss), 0);
    chk("R11 status", 32'(peek_status), 0);

    A = mk(1, 1, 0);
    do_req(A, 0, 0, "R2 cold read");
    do_req(A + 8, 0, 0, "R9 offset merge");
    do_fill(A, 1, "R6 shared fill");
    chk("R7 freed", 32'(find(A[31:4])), 32'hFFFFFFFF);
    do_req(A, 0, 0, "R4 read hit");
    chk("R4 ref", 32'(peek_status), 32'h15);
    do_req(A, 1, 0, "R3 upgrade miss");
    chk("R5 not readable", 32'(peek_status), 32'h11);
    do_req(A + 4, 0, 0, "R5 read blocked");
    do_fill(A, 0, "R6 excl fill");
    chk("R6 excl", 32'(peek_status), 32'h07);
    do_req(A, 1, 0, "R3 write hit");
    do_fill(mk(2, 5, 0), 1, "R7 unmatched fill");
    chk("R7 ignored", 32'(peek_status), 0);
    do_req(mk(3, 6, 0), 0, 1, "R8 wb absent");
    chk("R8 absent", 32'(peek_status), 32'h0D);
    do_req(A, 0, 1, "R8 wb present");
    chk("R8 present", 32'(peek_status), 32'h1F);
    for (int i = 0; i < 4; i++) do_req(mk(4, 8 + i, 0), i[0], 0, "R10 fill table");
    chk("R10 full", 32'(stall), 1);
    do_req(mk(4, 12, 0), 0, 0, "R10 rejected");
    do_req(A, 0, 0, "R10 hit while full");
    do_req(mk(4, 8, 12), 0, 0, "R9 merge while full");
    for (int i = 0; i < 4; i++) do_fill(mk(4, 8 + i, 0), 1'b0, "R7 drain");
    chk("R10 drained", 32'(stall), 0);

    for (int it = 0; it < 3000; it++) begin
      int r = $urandom % 100;
      logic [31:0] a = mk($urandom % 3, $urandom % 4, $urandom % 16);
      if (r < 55) begin
        int k = $urandom % 10;
        do_req(a, k < 4, k == 9, k == 9 ? "R8 rnd" : (k < 4 ? "R3 rnd" : "R2 rnd"));
      end else if (r < 90) begin
        int f = -1;
        for (int i = 0; i < 4; i++) if (ev[i] && ($urandom % 2 == 0 || f < 0)) f = i;
        if (f >= 0 && r < 85) do_fill({ea[f], 4'($urandom)}, !ex[f] && ($urandom % 2 == 1), "R6 rnd fill");
        else if (find(a[31:4]) < 0) do_fill(a, $urandom % 2 == 1, "R7 rnd stray");
      end else @(negedge clk);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule